// File: doc/BRIEF.md
# Four-Way Serial Line Contention Arbiter

This block lets several sub-channel ports share a single master synchronous serial port. Each sub-channel asks for the master port either by holding its request lead active or by sending data that toggles. The block picks one requesting channel and grants it the master port. It forwards the winner's sampled data bit and request lead to the master side. After a programmable delay it raises clear-to-send back to the winner.

Once granted, a channel keeps the master port until one of three things happens: its request lead falls, it is disabled, or its data stays unchanged for a programmable run of bit clocks. When that idle timeout removes a channel that is still holding its lead, the channel cannot win again until it drops the lead. This stops a stuck terminal from holding the line indefinitely.

Two selection orders are available. Priority mode always favours the lowest-numbered channel. Scan mode searches in rotation, starting at the channel after the one most recently released. Timing comes from a bit-clock enable for data sampling and idle counting, and from a millisecond tick for the clear-to-send delay.

Top module: `contend_arbiter`

## Requirements
- R1: `grant` has at most one bit set. A bit can only become set for a channel that was requesting in the previous cycle.
- R2: With `prio_mode`=1, the lowest-numbered requesting channel wins, where channel 0 is bit 0.
- R3: With `prio_mode`=0, the winner is the first requesting channel found by searching upward with wraparound. The search starts at the channel after the last released owner, or at channel 0 after reset.
- R4: When `use_data[i]`=1, channel i requests while its latest two `rxd` samples differ. Samples are taken on cycles where `bit_tick`=1. When `use_data[i]`=0, channel i requests while `req_lead[i]` is high, and data transitions have no effect.
- R5: An owner keeps the grant while it holds its request, and other channels' requests cannot take it away. A lead-mode owner loses the grant at the second clock edge after `req_lead` falls.
- R6: `idle_sel` codes 0, 1, 2 and 3 select 16, 64, 256 and 2048 consecutive bit ticks with no `rxd` change on the owner. After that many ticks the grant is released, so it lasts N+1 cycles when data is static and `bit_tick` is held high. A lead-mode owner released by this timeout cannot be granted again until its lead has gone low.
- R7: `cts_sel` code 0 raises clear-to-send in the same cycle as the grant. Code k (1 to 7) raises it in the cycle after the 2^(k-1)th `ms_tick` counted while the grant is held.
- R8: `cts` is only ever set for the granted channel. It falls in the same cycle as the grant.
- R9: A channel whose `chan_en` bit is low is never granted. An owner whose enable falls loses the grant at the next edge.
- R10: `mst_txd` and `mst_rts` carry the owner's sampled data and registered request lead. Both are 0 when no channel is granted.
- R11: `chan_busy[i]` shows the enabled channel's request activity as defined in R4, whether or not the channel is granted.
- R12: While reset is asserted, and in the first cycle after it ends, `grant`, `cts`, `mst_txd` and `mst_rts` are all 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | Bit-clock enable for data sampling and idle counting |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| chan_en | input | NCH | Per-channel enable |
| req_lead | input | NCH | Per-channel request control lead |
| rxd | input | NCH | Per-channel serial data |
| use_data | input | NCH | Per-channel request mode: 1 means data transitions, 0 means the lead |
| prio_mode | input | 1 | 1 selects fixed priority, 0 selects rotating scan |
| idle_sel | input | 2 | Idle timeout code |
| cts_sel | input | 3 | Clear-to-send delay code |
| grant | output | NCH | One-hot grant of the master port |
| cts | output | NCH | Clear-to-send to each channel |
| chan_busy | output | NCH | Per-channel activity indicator |
| mst_txd | output | 1 | Owner data forwarded to the master port |
| mst_rts | output | 1 | Owner request lead forwarded to the master port |

## Verification
Some properties are checked on every cycle by assertions:
- the grant stays one-hot;
- clear-to-send never appears outside the grant and follows it at once when the delay code is zero;
- a held grant never moves directly to another channel;
- newly won grants only go to enabled channels;
- the master-side outputs are quiet when there is no owner.

Other behaviour depends on history, so only the bench scenarios can show it:
- the rotating search order across successive releases;
- the exact idle-timeout length;
- the lockout of a timed-out lead holder;
- the millisecond count before clear-to-send;
- the indifference of lead-mode channels to data.

// File: rtl/contend_pkg.sv
package contend_pkg;

  localparam int unsigned IDLE_MAX = 2048;
  localparam int unsigned IDLE_CW  = $clog2(IDLE_MAX + 1);
  localparam int unsigned MS_MAX   = 64;
  localparam int unsigned MS_CW    = $clog2(MS_MAX + 1);

  // Idle bit ticks allowed before an owner is released.
  function automatic logic [IDLE_CW-1:0] idle_limit(input logic [1:0] code);
    logic [IDLE_CW-1:0] lim;
    case (code)
      2'd0:    lim = IDLE_CW'(16);
      2'd1:    lim = IDLE_CW'(64);
      2'd2:    lim = IDLE_CW'(256);
      default: lim = IDLE_CW'(IDLE_MAX);
    endcase
    return lim;
  endfunction

  // Millisecond ticks between grant and clear-to-send.
  function automatic logic [MS_CW-1:0] cts_wait(input logic [2:0] code);
    logic [MS_CW-1:0] w;
    if (code == 3'd0) w = '0;
    else              w = MS_CW'(1) << (code - 3'd1);
    return w;
  endfunction

endpackage

// File: rtl/contend_line_sampler.sv
module contend_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic req_lead,
  input  logic rxd,
  output logic lead_q,
  output logic data_q,
  output logic edge_now,
  output logic moved
);
  logic lead_r, lead_n;
  logic cur_r, cur_n;
  logic prv_r, prv_n;

  always_comb begin
    lead_n = req_lead;
    cur_n  = cur_r;
    prv_n  = prv_r;
    if (bit_tick) begin
      cur_n = rxd;
      prv_n = cur_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_r <= 1'b0;
      cur_r  <= 1'b0;
      prv_r  <= 1'b0;
    end else begin
      lead_r <= lead_n;
      cur_r  <= cur_n;
      prv_r  <= prv_n;
    end
  end

  assign lead_q   = lead_r;
  assign data_q   = cur_r;
  assign edge_now = bit_tick & (rxd ^ cur_r);
  assign moved    = cur_r ^ prv_r;

endmodule

// File: rtl/contend_grant_picker.sv
module contend_grant_picker #(
  parameter int NCH = 4,
  parameter int PW  = 2
) (
  input  logic [NCH-1:0] req,
  input  logic [PW-1:0]  ptr,
  input  logic           prio_mode,
  output logic [NCH-1:0] win,
  output logic           any
);
  always_comb begin
    logic          found;
    logic [PW:0]   s;
    logic [PW-1:0] jj;
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      s = {1'b0, ptr} + (PW+1)'(k);
      if (s >= (PW+1)'(NCH)) s = s - (PW+1)'(NCH);
      jj = prio_mode ? PW'(k) : s[PW-1:0];
      if (!found && req[jj]) begin
        win[jj] = 1'b1;
        found   = 1'b1;
      end
    end
    any = found;
  end

endmodule

// File: rtl/contend_idle_watch.sv
module contend_idle_watch
  import contend_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       owned,
  input  logic       tick,
  input  logic       owner_edge,
  input  logic [1:0] code,
  output logic       expire
);
  logic [IDLE_CW-1:0] cnt_r, cnt_n;
  logic [IDLE_CW-1:0] lim;

  assign lim = idle_limit(code);

  always_comb begin
    cnt_n = cnt_r;
    if (!owned) begin
      cnt_n = '0;
    end else if (tick) begin
      if (owner_edge)       cnt_n = '0;
      else if (cnt_r < lim) cnt_n = cnt_r + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_r <= '0;
    else        cnt_r <= cnt_n;
  end

  assign expire = owned & (cnt_r >= lim);

endmodule

// File: rtl/contend_cts_gen.sv
module contend_cts_gen
  import contend_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       owned,
  input  logic       ms_tick,
  input  logic [2:0] code,
  output logic       ready
);
  logic [MS_CW-1:0] cnt_r, cnt_n;

  always_comb begin
    cnt_n = cnt_r;
    if (!owned)                                    cnt_n = '0;
    else if (ms_tick && cnt_r < MS_CW'(MS_MAX))    cnt_n = cnt_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_r <= '0;
    else        cnt_r <= cnt_n;
  end

  assign ready = owned & (cnt_r >= cts_wait(code));

endmodule

// File: rtl/contend_arbiter.sv
module contend_arbiter #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_tick,
  input  logic           ms_tick,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] req_lead,
  input  logic [NCH-1:0] rxd,
  input  logic [NCH-1:0] use_data,
  input  logic           prio_mode,
  input  logic [1:0]     idle_sel,
  input  logic [2:0]     cts_sel,
  output logic [NCH-1:0] grant,
  output logic [NCH-1:0] cts,
  output logic [NCH-1:0] chan_busy,
  output logic           mst_txd,
  output logic           mst_rts
);
  localparam int PW = (NCH > 1) ? $clog2(NCH) : 1;

  // reset: asserted at once, released on the clock
  logic [1:0] rs_r;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_r <= 2'b00;
    else        rs_r <= {rs_r[0], 1'b1};
  end
  assign rst_core_n = rs_r[1];

  logic [NCH-1:0] lead_v, data_v, edge_v, moved_v;
  logic [NCH-1:0] act_v, hold_v, req_v;

  for (genvar g = 0; g < NCH; g++) begin : g_line
    contend_line_sampler u_line (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .bit_tick (bit_tick),
      .req_lead (req_lead[g]),
      .rxd      (rxd[g]),
      .lead_q   (lead_v[g]),
      .data_q   (data_v[g]),
      .edge_now (edge_v[g]),
      .moved    (moved_v[g])
    );
    assign act_v[g]  = use_data[g] ? moved_v[g] : lead_v[g];
    assign hold_v[g] = chan_en[g] & (use_data[g] | lead_v[g]);
  end

  logic [NCH-1:0] grant_r, grant_n;
  logic [NCH-1:0] lock_r, lock_n;
  logic [PW-1:0]  ptr_r, ptr_n;
  logic [PW-1:0]  own_idx;
  logic [NCH-1:0] win;
  logic           win_any;
  logic           owned, owner_edge, withdraw, expire, release_now, cts_ok;

  assign chan_busy  = chan_en & act_v;
  assign req_v      = chan_busy & ~lock_r;
  assign owned      = |grant_r;
  assign owner_edge = |(grant_r & edge_v);
  assign withdraw   = |(grant_r & ~hold_v);

  contend_grant_picker #(.NCH(NCH), .PW(PW)) u_pick (
    .req       (req_v),
    .ptr       (ptr_r),
    .prio_mode (prio_mode),
    .win       (win),
    .any       (win_any)
  );

  contend_idle_watch u_idle (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .owned      (owned),
    .tick       (bit_tick),
    .owner_edge (owner_edge),
    .code       (idle_sel),
    .expire     (expire)
  );

  contend_cts_gen u_cts (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .owned   (owned),
    .ms_tick (ms_tick),
    .code    (cts_sel),
    .ready   (cts_ok)
  );

  assign release_now = owned & (withdraw | expire);

  always_comb begin
    own_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant_r[i]) own_idx = PW'(i);
    end
  end

  always_comb begin
    grant_n = grant_r;
    ptr_n   = ptr_r;
    lock_n  = lock_r & act_v;
    if (!owned) begin
      if (win_any) grant_n = win;
    end else if (release_now) begin
      grant_n = '0;
      ptr_n   = (own_idx == PW'(NCH-1)) ? '0 : own_idx + 1'b1;
      if (expire) lock_n = lock_n | grant_r;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      grant_r <= '0;
      lock_r  <= '0;
      ptr_r   <= '0;
    end else begin
      grant_r <= grant_n;
      lock_r  <= lock_n;
      ptr_r   <= ptr_n;
    end
  end

  assign grant   = grant_r;
  assign cts     = grant_r & {NCH{cts_ok}};
  assign mst_txd = |(grant_r & data_v);
  assign mst_rts = |(grant_r & lead_v);

endmodule

// File: rtl/contend_arbiter_chk.sv
module contend_arbiter_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_en,
  input logic [2:0]     cts_sel,
  input logic [NCH-1:0] grant,
  input logic [NCH-1:0] cts,
  input logic           mst_txd,
  input logic           mst_rts
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r8_cts_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (cts & ~grant) == '0);

  a_r8_cts_falls: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|grant) |-> (cts == '0));

  a_r7_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_sel == 3'd0) |-> (cts == grant));

  a_r5_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant) && $past(|grant)) |-> $stable(grant));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |-> (!mst_txd && !mst_rts));

  for (genvar g = 0; g < NCH; g++) begin : g_en
    a_r9_enabled_win: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant[g]) |-> $past(chan_en[g]));
  end

endmodule

bind contend_arbiter contend_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .chan_en (chan_en),
  .cts_sel (cts_sel),
  .grant   (grant),
  .cts     (cts),
  .mst_txd (mst_txd),
  .mst_rts (mst_rts)
);

// File: tb/tb_contend_arbiter.sv
module tb_contend_arbiter;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           bit_tick, ms_tick, prio_mode;
  logic [NCH-1:0] chan_en, req_lead, rxd, use_data;
  logic [1:0]     idle_sel;
  logic [2:0]     cts_sel;
  logic [NCH-1:0] grant, cts, chan_busy;
  logic           mst_txd, mst_rts;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  contend_arbiter #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ms_tick(ms_tick),
    .chan_en(chan_en), .req_lead(req_lead), .rxd(rxd), .use_data(use_data),
    .prio_mode(prio_mode), .idle_sel(idle_sel), .cts_sel(cts_sel),
    .grant(grant), .cts(cts), .chan_busy(chan_busy),
    .mst_txd(mst_txd), .mst_rts(mst_rts)
  );

  // {prio_mode, req_lead, expected grant}; order matters for the scan pointer
  localparam logic [8:0] VEC [0:7] = '{
    9'b1_1010_0010,
    9'b1_1111_0001,
    9'b0_1111_0010,
    9'b0_0011_0001,
    9'b0_1001_1000,
    9'b0_1001_0001,
    9'b1_1100_0100,
    9'b0_0110_0010
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic hold_len(output int n);
    n = 0;
    while (grant != '0 && n < 200) begin
      n++;
      step(1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int len;
    rst_n = 1'b0; bit_tick = 1'b1; ms_tick = 1'b0; prio_mode = 1'b1;
    chan_en = '1; req_lead = '1; rxd = '0; use_data = '0;
    idle_sel = 2'd3; cts_sel = 3'd0;
    step(3);
    // R12: quiet in reset with all leads high
    check("R12 grant", grant, 0);
    check("R12 cts", cts, 0);
    check("R12 master", {mst_txd, mst_rts}, 0);
    req_lead = '0;
    rst_n = 1'b1;
    step(1);
    check("R12 after release", grant, 0);
    step(3);

    // R2 / R3 table
    for (int v = 0; v < 8; v++) begin
      prio_mode = VEC[v][8];
      req_lead  = VEC[v][7:4];
      step(4);
      check(VEC[v][8] ? "R2 priority pick" : "R3 scan pick", grant, VEC[v][3:0]);
      check("R10 rts forward", mst_rts, 1);
      req_lead = '0;
      step(4);
      check("R5 release on lead drop", grant, 0);
    end

    // R7 / R8: 4 ms delay (code 3)
    prio_mode = 1'b1; cts_sel = 3'd3; req_lead = 4'b0010;
    step(4);
    check("R7 granted", grant, 4'b0010);
    check("R7 cts held off", cts, 0);
    for (int p = 0; p < 3; p++) begin
      ms_tick = 1'b1; step(1); ms_tick = 1'b0; step(1);
    end
    check("R7 cts after 3 ms", cts, 0);
    ms_tick = 1'b1; step(1); ms_tick = 1'b0;
    check("R7 cts after 4 ms", cts, 4'b0010);
    req_lead = '0;
    step(1);
    check("R5 grant one edge after drop", grant, 4'b0010);
    step(1);
    check("R8 grant dropped", grant, 0);
    check("R8 cts dropped with grant", cts, 0);
    cts_sel = 3'd0;
    step(2);

    // R9: disabled channel
    chan_en = 4'b1110; req_lead = 4'b0001;
    step(4);
    check("R9 disabled not granted", grant, 0);
    check("R11 disabled not busy", chan_busy, 0);
    req_lead = 4'b0101;
    step(4);
    check("R9 enabled wins", grant, 4'b0100);
    chan_en = 4'b1010;
    step(1);
    check("R9 owner disabled released", grant, 0);
    step(2);
    check("R9 none granted", grant, 0);
    req_lead = '0; chan_en = '1;
    step(3);

    // R11
    req_lead = 4'b0100;
    step(2);
    check("R11 busy", chan_busy, 4'b0100);
    req_lead = '0;
    step(3);

    // R4 / R6: data-mode request and 16-tick timeout
    use_data = 4'b0100; idle_sel = 2'd0;
    rxd[1] = 1'b1;
    step(3);
    check("R4 lead-mode data ignored", grant, 0);
    rxd[2] = 1'b1;
    step(1);
    check("R4 not yet granted", grant, 0);
    step(1);
    check("R4 data transition grant", grant, 4'b0100);
    check("R8 cts with grant", cts, 4'b0100);
    hold_len(len);
    check("R6 data timeout length", len, 17);
    check("R8 cts off after timeout", cts, 0);
    use_data = '0;
    step(3);

    // R6: lead-mode timeout and lockout
    req_lead = 4'b1000;
    step(2);
    check("R6 lead grant", grant, 4'b1000);
    hold_len(len);
    check("R6 lead timeout length", len, 17);
    step(5);
    check("R6 locked out", grant, 0);
    req_lead = '0;
    step(3);
    req_lead = 4'b1000;
    step(3);
    check("R6 re-grant after lead cycled", grant, 4'b1000);
    req_lead = '0; idle_sel = 2'd3;
    step(3);

    // R10: data pass-through
    rxd = '0;
    req_lead = 4'b0010;
    step(3);
    check("R10 txd low", mst_txd, 0);
    rxd[1] = 1'b1;
    step(2);
    check("R10 txd follows owner", mst_txd, 1);
    rxd[3] = 1'b0;
    req_lead = '0;
    step(3);
    check("R10 quiet without owner", {mst_txd, mst_rts}, 0);

    // R5 / R1: no preemption
    prio_mode = 1'b1;
    req_lead = 4'b1000;
    step(3);
    check("R1 single owner", grant, 4'b1000);
    req_lead = 4'b1001;
    step(3);
    check("R5 no preemption", grant, 4'b1000);
    req_lead = 4'b0001;
    step(4);
    check("R2 next owner after release", grant, 4'b0001);
    req_lead = '0;
    step(3);

    summary();
    $finish;
  end

endmodule